// File: doc/BRIEF.md
# Memory Encryption Request Steering Unit

This block stands between a processor's memory request port and the DRAM controller. For each request it decides whether the data has to pass through the inline encryption engine and which key slot the engine should use. It also strips the encryption tag from the physical address before the address goes on toward DRAM. The tag is one bit carried inside the request address. The key slot comes from the requester's address-space identifier (ASID). ASID 0 is the host or hypervisor and uses slot 0. Guest ASIDs map one-to-one onto slots 1 upward.

Several rules adjust the raw tag bit. A transparent mode, captured from a strap while reset is asserted, makes every request encrypted. A requester that does not control its own tag (the legacy flag) has its tag forced to 1. DMA traffic is always treated as shared, which forces the tag to 0. A shared request uses the host key slot whenever it is encrypted.

Key slots start out invalid after every reset. A load strobe marks a slot valid once its fresh key is in place. A request that needs encryption on a slot that is not yet valid is held off until the slot becomes valid. A request whose ASID is beyond the configured slot count is answered with a one-cycle error pulse and is never forwarded.

Top module: `mem_crypt_steer`

## Requirements
- R1: A forwarded request carries only address bits [LOC_W-1:0] (bits 45:0 by default) on `dram_addr`. The tag bit at TAG_POS (bit 47) and the unused bit 46 never reach DRAM.
- R2: With transparent mode off and no forcing flag, `dram_enc` equals the request's tag bit. The key index is the ASID when the tag is 1 and 0 when the tag is 0.
- R3: The transparent mode is the value of `tme_strap` sampled while `rst` is high. When it is set, every forwarded request has `dram_enc` = 1. Changes of `tme_strap` after reset has been released have no effect.
- R4: When `req_legacy` is 1 and `req_dma` is 0, the effective tag is 1 whatever address bit 47 holds. The request is then encrypted with key index equal to its ASID.
- R5: When `req_dma` is 1, the effective tag is 0. This overrides both the address bit and `req_legacy`. The key index is 0, and `dram_enc` equals the transparent mode.
- R6: Reset marks every key slot invalid. A cycle with `key_load_vld` = 1 marks slot `key_load_idx` valid from the next cycle on.
- R7: While a valid request needs encryption and its key slot is invalid, `req_ready` is 0. It rises in the cycle after the slot is loaded.
- R8: An accepted request appears on the DRAM side on the next clock edge. While `dram_valid` = 1 and `dram_ready` = 0, the DRAM-side outputs hold steady and `req_ready` is 0.
- R9: A request with ASID >= NUM_SLOTS is accepted without any key check. It raises `err_valid` for exactly the next cycle and produces no DRAM-side transfer.
- R10: After reset, `dram_valid` and `err_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tme_strap | input | 1 | Transparent-mode strap, sampled during reset |
| key_load_vld | input | 1 | Marks one key slot as loaded |
| key_load_idx | input | ASID_W | Slot being marked valid |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | PA_W | Physical address including the tag bit |
| req_asid | input | ASID_W | Requester address-space identifier |
| req_dma | input | 1 | Request comes from a DMA agent |
| req_legacy | input | 1 | Requester does not control its tag bit |
| dram_valid | output | 1 | Forwarded request present |
| dram_ready | input | 1 | DRAM side accepts the forwarded request |
| dram_addr | output | LOC_W | Address without the tag bit |
| dram_enc | output | 1 | Route data through the encryption engine |
| dram_key | output | KEY_W | Key slot index for the engine |
| err_valid | output | 1 | One-cycle error for an out-of-range ASID |

## Verification
The bench builds the block with NUM_SLOTS = 8 and a 4-bit ASID. Half of the ASID space is therefore out of range, so one sweep covers every ASID, both tag values and all four combinations of the DMA and legacy flags. The sweep runs once with transparent mode off and once with it on. The small slot count also keeps a full load of every key slot short. That makes it cheap to observe the stall on an unloaded slot, and the clearing of slots by reset, in each run.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    localparam int MCS_PA_W      = 48;
    localparam int MCS_LOC_W     = 46;
    localparam int MCS_TAG_POS   = 47;
    localparam int MCS_ASID_W    = 6;
    localparam int MCS_NUM_SLOTS = 16;

    typedef enum logic [1:0] {
        RT_PLAIN  = 2'd0,
        RT_CRYPT  = 2'd1,
        RT_REJECT = 2'd2
    } mcs_route_e;

    typedef struct packed {
        mcs_route_e kind;
        logic       tag_eff;
    } mcs_route_t;

    // Effective tag after the DMA and legacy overrides (DMA wins).
    function automatic logic mcs_eff_tag(input logic raw_tag,
                                         input logic dma,
                                         input logic legacy);
        if (dma)         return 1'b0;
        else if (legacy) return 1'b1;
        else             return raw_tag;
    endfunction

endpackage

// File: rtl/mcs_decode.sv
module mcs_decode
    import mcs_pkg::*;
#(
    parameter int PA_W      = MCS_PA_W,
    parameter int LOC_W     = MCS_LOC_W,
    parameter int TAG_POS   = MCS_TAG_POS,
    parameter int ASID_W    = MCS_ASID_W,
    parameter int NUM_SLOTS = MCS_NUM_SLOTS,
    parameter int KEY_W     = $clog2(NUM_SLOTS)
) (
    input  logic [PA_W-1:0]   addr,
    input  logic [ASID_W-1:0] asid,
    input  logic              dma,
    input  logic              legacy,
    input  logic              tme,
    output mcs_route_t        route,
    output logic [KEY_W-1:0]  key,
    output logic [LOC_W-1:0]  loc
);

    logic tag;
    logic out_of_range;

    assign tag          = mcs_eff_tag(addr[TAG_POS], dma, legacy);
    assign out_of_range = ({1'b0, asid} >= (ASID_W+1)'(NUM_SLOTS));
    assign loc          = addr[LOC_W-1:0];
    assign key          = tag ? asid[KEY_W-1:0] : '0;

    always_comb begin
        route.tag_eff = tag;
        if (out_of_range)     route.kind = RT_REJECT;
        else if (tme || tag)  route.kind = RT_CRYPT;
        else                  route.kind = RT_PLAIN;
    end

endmodule

// File: rtl/mcs_key_table.sv
module mcs_key_table
    import mcs_pkg::*;
#(
    parameter int ASID_W    = MCS_ASID_W,
    parameter int NUM_SLOTS = MCS_NUM_SLOTS,
    parameter int KEY_W     = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_vld,
    input  logic [ASID_W-1:0]    load_idx,
    input  logic [KEY_W-1:0]     look_idx,
    output logic                 look_ok,
    output logic [NUM_SLOTS-1:0] slot_vld
);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_vld[s] <= 1'b0;
            else if (load_vld && (load_idx == ASID_W'(s)))
                slot_vld[s] <= 1'b1;
        end
    end

    assign look_ok = slot_vld[look_idx];

endmodule

// File: rtl/mcs_out_stage.sv
module mcs_out_stage
    import mcs_pkg::*;
#(
    parameter int LOC_W = MCS_LOC_W,
    parameter int KEY_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             err_load,
    input  logic [LOC_W-1:0] in_addr,
    input  logic             in_enc,
    input  logic [KEY_W-1:0] in_key,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [LOC_W-1:0] out_addr,
    output logic             out_enc,
    output logic [KEY_W-1:0] out_key,
    output logic             out_err,
    output logic             free
);

    assign free = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_err   <= 1'b0;
        end else begin
            out_err <= err_load;
            if (load)           out_valid <= 1'b1;
            else if (out_ready) out_valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_addr <= '0;
            out_enc  <= 1'b0;
            out_key  <= '0;
        end else if (load) begin
            out_addr <= in_addr;
            out_enc  <= in_enc;
            out_key  <= in_key;
        end
    end

endmodule

// File: rtl/mem_crypt_steer.sv
module mem_crypt_steer
    import mcs_pkg::*;
#(
    parameter int PA_W      = MCS_PA_W,
    parameter int LOC_W     = MCS_LOC_W,
    parameter int TAG_POS   = MCS_TAG_POS,
    parameter int ASID_W    = MCS_ASID_W,
    parameter int NUM_SLOTS = MCS_NUM_SLOTS,
    localparam int KEY_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tme_strap,
    input  logic              key_load_vld,
    input  logic [ASID_W-1:0] key_load_idx,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PA_W-1:0]   req_addr,
    input  logic [ASID_W-1:0] req_asid,
    input  logic              req_dma,
    input  logic              req_legacy,
    output logic              dram_valid,
    input  logic              dram_ready,
    output logic [LOC_W-1:0]  dram_addr,
    output logic              dram_enc,
    output logic [KEY_W-1:0]  dram_key,
    output logic              err_valid
);

    logic                 tme_q;
    mcs_route_t           route;
    logic [KEY_W-1:0]     key_sel;
    logic [LOC_W-1:0]     loc;
    logic                 key_ok;
    logic [NUM_SLOTS-1:0] slot_vld;
    logic                 out_free;
    logic                 accept;
    logic                 fwd_load;
    logic                 err_load;

    // Transparent mode is captured only while reset is held.
    always_ff @(posedge clk) begin
        if (rst) tme_q <= tme_strap;
    end

    mcs_decode #(
        .PA_W(PA_W), .LOC_W(LOC_W), .TAG_POS(TAG_POS),
        .ASID_W(ASID_W), .NUM_SLOTS(NUM_SLOTS), .KEY_W(KEY_W)
    ) u_decode (
        .addr(req_addr), .asid(req_asid), .dma(req_dma),
        .legacy(req_legacy), .tme(tme_q),
        .route(route), .key(key_sel), .loc(loc)
    );

    mcs_key_table #(
        .ASID_W(ASID_W), .NUM_SLOTS(NUM_SLOTS), .KEY_W(KEY_W)
    ) u_keys (
        .clk(clk), .rst(rst),
        .load_vld(key_load_vld), .load_idx(key_load_idx),
        .look_idx(key_sel), .look_ok(key_ok), .slot_vld(slot_vld)
    );

    always_comb begin
        unique case (route.kind)
            RT_REJECT: req_ready = out_free;
            RT_CRYPT:  req_ready = out_free && key_ok;
            default:   req_ready = out_free;
        endcase
    end

    assign accept   = req_valid && req_ready;
    assign err_load = accept && (route.kind == RT_REJECT);
    assign fwd_load = accept && (route.kind != RT_REJECT);

    mcs_out_stage #(
        .LOC_W(LOC_W), .KEY_W(KEY_W)
    ) u_out (
        .clk(clk), .rst(rst),
        .load(fwd_load), .err_load(err_load),
        .in_addr(loc), .in_enc(route.kind == RT_CRYPT), .in_key(key_sel),
        .out_ready(dram_ready),
        .out_valid(dram_valid), .out_addr(dram_addr),
        .out_enc(dram_enc), .out_key(dram_key),
        .out_err(err_valid), .free(out_free)
    );

endmodule

// File: rtl/mcs_chk.sv
module mcs_chk #(
    parameter int PA_W      = 48,
    parameter int LOC_W     = 46,
    parameter int ASID_W    = 6,
    parameter int NUM_SLOTS = 16,
    parameter int KEY_W     = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [PA_W-1:0]      req_addr,
    input logic [ASID_W-1:0]    req_asid,
    input logic                 req_dma,
    input logic                 dram_valid,
    input logic                 dram_ready,
    input logic [LOC_W-1:0]     dram_addr,
    input logic                 dram_enc,
    input logic [KEY_W-1:0]     dram_key,
    input logic                 err_valid,
    input logic                 tme_q,
    input logic [NUM_SLOTS-1:0] slot_vld
);

    logic acc;
    logic bad;
    assign acc = req_valid && req_ready;
    assign bad = ({1'b0, req_asid} >= (ASID_W+1)'(NUM_SLOTS));

    // R1
    addr_strip_chk: assert property (@(posedge clk) disable iff (rst)
        acc && !bad |=> dram_valid && dram_addr == $past(req_addr[LOC_W-1:0]));

    // R3
    transparent_chk: assert property (@(posedge clk) disable iff (rst)
        acc && !bad && tme_q |=> dram_enc);

    // R5
    dma_shared_chk: assert property (@(posedge clk) disable iff (rst)
        acc && !bad && req_dma |=> dram_key == '0 && dram_enc == tme_q);

    // R7
    key_valid_chk: assert property (@(posedge clk) disable iff (rst)
        dram_valid && dram_enc |-> slot_vld[dram_key]);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        dram_valid && !dram_ready |=> dram_valid && $stable(dram_addr)
            && $stable(dram_enc) && $stable(dram_key));

    // R9
    reject_chk: assert property (@(posedge clk) disable iff (rst)
        acc && bad |=> err_valid);

    // R9
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> $past(acc && bad));

endmodule

bind mem_crypt_steer mcs_chk #(
    .PA_W(PA_W), .LOC_W(LOC_W), .ASID_W(ASID_W),
    .NUM_SLOTS(NUM_SLOTS), .KEY_W(KEY_W)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_asid(req_asid), .req_dma(req_dma),
    .dram_valid(dram_valid), .dram_ready(dram_ready), .dram_addr(dram_addr),
    .dram_enc(dram_enc), .dram_key(dram_key), .err_valid(err_valid),
    .tme_q(tme_q), .slot_vld(slot_vld)
);

// File: tb/mem_crypt_steer_tb.sv
module mem_crypt_steer_tb_top;

    localparam int PA_W   = 48;
    localparam int LOC_W  = 46;
    localparam int ASID_W = 4;
    localparam int NSLOT  = 8;
    localparam int KEY_W  = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tme_strap = 1'b0;
    logic              key_load_vld = 1'b0;
    logic [ASID_W-1:0] key_load_idx = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [PA_W-1:0]   req_addr = '0;
    logic [ASID_W-1:0] req_asid = '0;
    logic              req_dma = 1'b0;
    logic              req_legacy = 1'b0;
    logic              dram_valid;
    logic              dram_ready = 1'b1;
    logic [LOC_W-1:0]  dram_addr;
    logic              dram_enc;
    logic [KEY_W-1:0]  dram_key;
    logic              err_valid;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    mem_crypt_steer #(
        .PA_W(PA_W), .LOC_W(LOC_W), .TAG_POS(47),
        .ASID_W(ASID_W), .NUM_SLOTS(NSLOT)
    ) dut_i (
        .clk(clk), .rst(rst), .tme_strap(tme_strap),
        .key_load_vld(key_load_vld), .key_load_idx(key_load_idx),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_asid(req_asid), .req_dma(req_dma), .req_legacy(req_legacy),
        .dram_valid(dram_valid), .dram_ready(dram_ready), .dram_addr(dram_addr),
        .dram_enc(dram_enc), .dram_key(dram_key), .err_valid(err_valid)
    );

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic tme);
        @(negedge clk);
        rst = 1'b1;
        tme_strap = tme;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        tme_strap = ~tme;  // R3: later strap changes must be ignored
        #1;
        check("R10 dram_valid after reset", 64'(dram_valid), 64'd0);
        check("R10 err_valid after reset", 64'(err_valid), 64'd0);
    endtask

    task automatic load_key(input int idx);
        @(negedge clk);
        key_load_vld = 1'b1;
        key_load_idx = ASID_W'(idx);
        @(negedge clk);
        key_load_vld = 1'b0;
    endtask

    // Sends one request and checks the DRAM side against the rules.
    task automatic send(input logic tme, input int asid, input logic tag,
                        input logic dma, input logic legacy, input int seed);
        logic [LOC_W-1:0] loc;
        logic             t;
        logic             enc;
        logic [KEY_W-1:0] key;
        logic             bad;
        loc = LOC_W'(64'h2a5b_3c4d_5e6f) ^ LOC_W'(seed * 64'h1_0003_0507);
        bad = (asid >= NSLOT);
        t   = dma ? 1'b0 : (legacy ? 1'b1 : tag);
        enc = tme | t;
        key = t ? KEY_W'(asid) : '0;
        @(negedge clk);
        req_addr   = {tag, 1'b1, loc};
        req_asid   = ASID_W'(asid);
        req_dma    = dma;
        req_legacy = legacy;
        req_valid  = 1'b1;
        #1;
        check("R7 ready with keys loaded", 64'(req_ready), 64'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (bad) begin
            check("R9 err_valid for wide ASID", 64'(err_valid), 64'd1);
            check("R9 no forward for wide ASID", 64'(dram_valid), 64'd0);
        end else begin
            check("R8 dram_valid one cycle later", 64'(dram_valid), 64'd1);
            check("R1 address stripped", 64'(dram_addr), 64'(loc));
            if (dma)              check("R5 dma enc", 64'(dram_enc), 64'(enc));
            else if (tme)         check("R3 transparent enc", 64'(dram_enc), 64'(enc));
            else if (legacy)      check("R4 legacy enc", 64'(dram_enc), 64'(enc));
            else                  check("R2 tag enc", 64'(dram_enc), 64'(enc));
            if (dma)              check("R5 dma key", 64'(dram_key), 64'(key));
            else if (legacy)      check("R4 legacy key", 64'(dram_key), 64'(key));
            else                  check("R2 key index", 64'(dram_key), 64'(key));
            check("R9 no error for valid ASID", 64'(err_valid), 64'd0);
        end
    endtask

    task automatic sweep(input logic tme);
        int seed = 0;
        for (int a = 0; a < 16; a++)
            for (int m = 0; m < 8; m++) begin
                send(tme, a, m[0], m[1], m[2], seed);
                seed++;
            end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // Phase 1: transparent mode off
        do_reset(1'b0);

        // R2: untagged request needs no key, passes with no slots loaded
        send(1'b0, 3, 1'b0, 1'b0, 1'b0, 99);

        // R6 / R7: tagged request on unloaded slot 3 stalls
        @(negedge clk);
        req_addr  = {1'b1, 1'b0, 46'h0abc_def0_1234};
        req_asid  = 4'd3;
        req_dma   = 1'b0;
        req_legacy = 1'b0;
        req_valid = 1'b1;
        #1;
        check("R7 stall on invalid slot", 64'(req_ready), 64'd0);
        @(negedge clk);
        check("R6 slot invalid after reset", 64'(req_ready), 64'd0);
        key_load_vld = 1'b1;
        key_load_idx = 4'd3;
        @(negedge clk);
        key_load_vld = 1'b0;
        #1;
        check("R7 ready after key load", 64'(req_ready), 64'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 forwarded after load", 64'(dram_valid), 64'd1);
        check("R7 enc after load", 64'(dram_enc), 64'd1);
        check("R7 key after load", 64'(dram_key), 64'd3);

        for (int k = 0; k < NSLOT; k++) load_key(k);
        sweep(1'b0);

        // R8: backpressure
        @(negedge clk);
        dram_ready = 1'b0;
        req_addr   = {1'b0, 1'b0, 46'h1111_2222_3333};
        req_asid   = 4'd1;
        req_dma    = 1'b0;
        req_legacy = 1'b0;
        req_valid  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_addr = {1'b0, 1'b0, 46'h0444_5555_6666};
        #1;
        check("R8 ready low when output full", 64'(req_ready), 64'd0);
        @(negedge clk);
        check("R8 hold valid", 64'(dram_valid), 64'd1);
        check("R8 hold address", 64'(dram_addr), 64'h1111_2222_3333);
        dram_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 second request after drain", 64'(dram_addr), 64'h0444_5555_6666);

        // Phase 2: transparent mode on
        do_reset(1'b1);
        @(negedge clk);
        req_addr  = {1'b0, 1'b0, 46'h0};
        req_asid  = 4'd2;
        req_dma   = 1'b0;
        req_legacy = 1'b0;
        req_valid = 1'b1;
        #1;
        check("R6 reset clears slot 0 (transparent stall)", 64'(req_ready), 64'd0);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < NSLOT; k++) load_key(k);
        sweep(1'b1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule